// File: doc/BRIEF.md
# Operand Address Relocation and Protection Unit

This block converts a 24-bit program operand address into a 17-bit physical word address and applies store protection on the way. It splits the operand into an address type, an 18-bit word offset and a 3-bit sub-word selector. It rejects address types a user program may not use. It relocates the offset against a per-job base that is held in 512-word granules, and checks the offset against the job's allocated length. It also checks the relocated word against a window of the store that a block transfer currently holds. An access that hits that window gets a distinct code, so the scheduler can switch to another job instead of treating the access as an error.

Three regions can be configured through a privileged write port, each as a pair of granule counts (base and length): the job's main space and two buffer regions. The address type picks the region. The decode is combinational and ends in one output register, so a result appears one cycle after its request. Only the highest-priority fault is reported, and a faulted access never presents a physical address.

Top module: `addr_reloc_unit`

## Requirements
- R1: The operand splits as bits [23:21] = type, bits [20:3] = word offset, bits [2:0] = sub-word selector. The selector of every request appears on `out_sel` with its result, whether or not the access faults.
- R2: A type whose bit 23 is 1 (types 100 to 111), or the reserved type 011, gives fault code 1 (illegal type).
- R3: Type 000 uses the main region (write select 0), type 001 buffer region A (select 1) and type 010 buffer region B (select 2). The physical address is base×512 + offset.
- R4: An offset at or beyond length×512 of the chosen region gives fault code 2 (out of bounds). So does a relocated address at or above 131,072.
- R5: When `lock_on` is 1 and the relocated address lies in the inclusive window [`lock_lo`, `lock_hi`], the access gives fault code 3 (wait for transfer). When `lock_on` is 0 the window has no effect.
- R6: Fault priority is code 1, then code 2, then code 3. Only one code is reported, and any nonzero code forces `out_phys` to 0. Code 0 means the access is granted.
- R7: `out_valid` is 1 in exactly the cycle after a cycle with `req` high. After a cycle without a request, `out_valid`, `out_phys`, `out_sel` and `out_fault` are all 0.
- R8: A write with `cfg_we` high loads `cfg_base` and `cfg_len` into the region named by `cfg_sel` at the clock edge. A request in the same cycle still sees the old values. A write with `cfg_sel` = 3 changes no region.
- R9: Reset clears all outputs and sets every base and length to 0. Any in-range access before configuration therefore reports code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Privileged region write strobe |
| cfg_sel | input | 2 | Region to write: 0 main, 1 buffer A, 2 buffer B |
| cfg_base | input | 8 | Region base in 512-word granules |
| cfg_len | input | 8 | Region length in 512-word granules |
| lock_on | input | 1 | Block-transfer lock window active |
| lock_lo | input | 17 | First physical word of the locked window |
| lock_hi | input | 17 | Last physical word of the locked window |
| req | input | 1 | Translation request |
| req_addr | input | 24 | Operand address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_phys | output | 17 | Physical word address, 0 on a fault |
| out_sel | output | 3 | Half-word or character selector |
| out_fault | output | 2 | 0 none, 1 illegal type, 2 out of bounds, 3 wait for transfer |

## Verification
The hardest cases to reach are those where two faults apply at once, because priority only shows when the lower fault would also have fired. Examples are an offset past the limit whose relocated word also falls in the locked window, and an illegal type issued while the window covers the whole store. Getting there needs region contents set by earlier writes and a lock window placed over the exact word the offset would reach. The vector table therefore places each window by hand, straddling a region's end or covering one word. A relocation near the top of the store, with base 255, drives the sum past 131,072 while the offset stays inside the region's length.

// File: rtl/addr_reloc_pkg.sv
package addr_reloc_pkg;

   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_ILLEGAL = 2'd1,
      FLT_BOUNDS  = 2'd2,
      FLT_LOCKED  = 2'd3
   } fault_e;

endpackage

// File: rtl/arl_field_split.sv
module arl_field_split #(
   parameter int ADDR_W  = 24,
   parameter int TYPE_W  = 3,
   parameter int SEL_W   = 3,
   parameter int NUM_REG = 3,
   localparam int OFF_W  = ADDR_W - TYPE_W - SEL_W,
   localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [OFF_W-1:0]  offset,
   output logic [SEL_W-1:0]  sub_sel,
   output logic [IDX_W-1:0]  region_idx,
   output logic              illegal
);

   logic [TYPE_W-1:0] type_f;

   assign type_f  = addr[ADDR_W-1 -: TYPE_W];
   assign offset  = addr[SEL_W +: OFF_W];
   assign sub_sel = addr[SEL_W-1:0];

   // Type values below NUM_REG map straight to a region; anything else,
   // including every type with its top bit set, is rejected.
   always_comb begin
      illegal    = 1'b1;
      region_idx = '0;
      for (int i = 0; i < NUM_REG; i++) begin
         if (type_f == TYPE_W'(i)) begin
            illegal    = 1'b0;
            region_idx = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/arl_region_regs.sv
module arl_region_regs #(
   parameter int NUM_REG = 3,
   parameter int CNT_W   = 8,
   localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [CNT_W-1:0] wr_base,
   input  logic [CNT_W-1:0] wr_len,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [CNT_W-1:0] rd_base,
   output logic [CNT_W-1:0] rd_len
);

   logic [CNT_W-1:0] base_q [NUM_REG];
   logic [CNT_W-1:0] len_q  [NUM_REG];

   for (genvar g = 0; g < NUM_REG; g++) begin : g_region
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[g] <= '0;
            len_q[g]  <= '0;
         end else if (wr_en && wr_idx == IDX_W'(g)) begin
            base_q[g] <= wr_base;
            len_q[g]  <= wr_len;
         end
      end
   end

   always_comb begin
      rd_base = '0;
      rd_len  = '0;
      for (int i = 0; i < NUM_REG; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_base = base_q[i];
            rd_len  = len_q[i];
         end
      end
   end

endmodule

// File: rtl/arl_bound_calc.sv
module arl_bound_calc #(
   parameter int OFF_W  = 18,
   parameter int CNT_W  = 8,
   parameter int GRAN_W = 9,
   parameter int PHYS_W = 17,
   localparam int SUM_W = OFF_W + 1
) (
   input  logic [OFF_W-1:0] offset,
   input  logic [CNT_W-1:0] base,
   input  logic [CNT_W-1:0] len,
   output logic [SUM_W-1:0] sum,
   output logic             oob
);

   logic [SUM_W-1:0] limit_w;
   logic [SUM_W-1:0] base_w;
   logic             past_len;
   logic             past_store;

   assign limit_w    = SUM_W'({len, {GRAN_W{1'b0}}});
   assign base_w     = SUM_W'({base, {GRAN_W{1'b0}}});
   assign sum        = base_w + SUM_W'(offset);
   assign past_len   = SUM_W'(offset) >= limit_w;
   assign past_store = |sum[SUM_W-1:PHYS_W];
   assign oob        = past_len | past_store;

endmodule

// File: rtl/arl_lock_cmp.sv
module arl_lock_cmp #(
   parameter int SUM_W  = 19,
   parameter int PHYS_W = 17
) (
   input  logic              lock_on,
   input  logic [PHYS_W-1:0] lock_lo,
   input  logic [PHYS_W-1:0] lock_hi,
   input  logic [SUM_W-1:0]  sum,
   output logic              hit
);

   assign hit = lock_on
              && (sum >= SUM_W'(lock_lo))
              && (sum <= SUM_W'(lock_hi));

endmodule

// File: rtl/addr_reloc_unit.sv
module addr_reloc_unit
   import addr_reloc_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int TYPE_W  = 3,
   parameter int SEL_W   = 3,
   parameter int NUM_REG = 3,
   parameter int CNT_W   = 8,
   parameter int GRAN_W  = 9,
   parameter int PHYS_W  = 17,
   localparam int OFF_W  = ADDR_W - TYPE_W - SEL_W,
   localparam int SUM_W  = OFF_W + 1,
   localparam int IDX_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_sel,
   input  logic [CNT_W-1:0]  cfg_base,
   input  logic [CNT_W-1:0]  cfg_len,
   input  logic              lock_on,
   input  logic [PHYS_W-1:0] lock_lo,
   input  logic [PHYS_W-1:0] lock_hi,
   input  logic              req,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              out_valid,
   output logic [PHYS_W-1:0] out_phys,
   output logic [SEL_W-1:0]  out_sel,
   output logic [1:0]        out_fault
);

   if (OFF_W < PHYS_W || CNT_W + GRAN_W > PHYS_W) begin : g_bad_widths
      initial $fatal(1, "addr_reloc_unit: offset or granule widths do not fit the physical width");
   end
   if (NUM_REG < 1 || NUM_REG > (1 << (TYPE_W - 1))) begin : g_bad_regions
      initial $fatal(1, "addr_reloc_unit: region count must fit the legal half of the type space");
   end

   logic [OFF_W-1:0]  offset;
   logic [SEL_W-1:0]  sub_sel;
   logic [IDX_W-1:0]  region_idx;
   logic              illegal;
   logic [CNT_W-1:0]  sel_base;
   logic [CNT_W-1:0]  sel_len;
   logic [SUM_W-1:0]  sum;
   logic              oob;
   logic              lock_hit;
   fault_e            fault_d;

   arl_field_split #(
      .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .SEL_W(SEL_W), .NUM_REG(NUM_REG)
   ) u_split (
      .addr(req_addr), .offset(offset), .sub_sel(sub_sel),
      .region_idx(region_idx), .illegal(illegal)
   );

   arl_region_regs #(
      .NUM_REG(NUM_REG), .CNT_W(CNT_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_sel), .wr_base(cfg_base), .wr_len(cfg_len),
      .rd_idx(region_idx), .rd_base(sel_base), .rd_len(sel_len)
   );

   arl_bound_calc #(
      .OFF_W(OFF_W), .CNT_W(CNT_W), .GRAN_W(GRAN_W), .PHYS_W(PHYS_W)
   ) u_bound (
      .offset(offset), .base(sel_base), .len(sel_len), .sum(sum), .oob(oob)
   );

   arl_lock_cmp #(
      .SUM_W(SUM_W), .PHYS_W(PHYS_W)
   ) u_lock (
      .lock_on(lock_on), .lock_lo(lock_lo), .lock_hi(lock_hi),
      .sum(sum), .hit(lock_hit)
   );

   always_comb begin
      if (illegal)       fault_d = FLT_ILLEGAL;
      else if (oob)      fault_d = FLT_BOUNDS;
      else if (lock_hit) fault_d = FLT_LOCKED;
      else               fault_d = FLT_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_phys  <= '0;
         out_sel   <= '0;
         out_fault <= FLT_NONE;
      end else begin
         out_valid <= req;
         out_sel   <= req ? sub_sel : '0;
         out_fault <= req ? fault_d : FLT_NONE;
         out_phys  <= (req && fault_d == FLT_NONE) ? sum[PHYS_W-1:0] : '0;
      end
   end

endmodule

// File: rtl/addr_reloc_chk.sv
module addr_reloc_chk #(
   parameter int ADDR_W = 24,
   parameter int SEL_W  = 3,
   parameter int PHYS_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic [ADDR_W-1:0] req_addr,
   input logic              out_valid,
   input logic [PHYS_W-1:0] out_phys,
   input logic [SEL_W-1:0]  out_sel,
   input logic [1:0]        out_fault
);

   // R7
   valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> out_valid);

   // R7
   idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (!out_valid && out_fault == 2'd0));

   // R1
   selector_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> out_sel == $past(req_addr[SEL_W-1:0]));

   // R2
   top_bit_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && req_addr[ADDR_W-1]) |=> out_fault == 2'd1);

   // R6
   fault_blanks_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_fault != 2'd0 |-> out_phys == '0);

endmodule

bind addr_reloc_unit addr_reloc_chk #(
   .ADDR_W(ADDR_W), .SEL_W(SEL_W), .PHYS_W(PHYS_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
   .out_valid(out_valid), .out_phys(out_phys), .out_sel(out_sel),
   .out_fault(out_fault)
);

// File: tb/tb_addr_reloc_unit.sv
module tb_addr_reloc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [7:0]  cfg_base = '0;
   logic [7:0]  cfg_len = '0;
   logic        lock_on = 1'b0;
   logic [16:0] lock_lo = '0;
   logic [16:0] lock_hi = '0;
   logic        req = 1'b0;
   logic [23:0] req_addr = '0;
   logic        out_valid;
   logic [16:0] out_phys;
   logic [2:0]  out_sel;
   logic [1:0]  out_fault;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   addr_reloc_unit dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_base(cfg_base), .cfg_len(cfg_len), .lock_on(lock_on),
      .lock_lo(lock_lo), .lock_hi(lock_hi), .req(req), .req_addr(req_addr),
      .out_valid(out_valid), .out_phys(out_phys), .out_sel(out_sel),
      .out_fault(out_fault)
   );

   typedef struct packed {
      logic [2:0]  ty;
      logic [17:0] off;
      logic [2:0]  sel;
      logic        lk;
      logic [16:0] lo;
      logic [16:0] hi;
      logic [1:0]  f;
      logic [16:0] ph;
   } vec_t;

   localparam int NV = 17;
   // Regions: main base 4 len 2, buffer A base 10 len 1, buffer B base 255 len 2
   localparam vec_t VECS [NV] = '{
      '{3'd0, 18'd5,    3'd3, 1'b0, 17'd0,    17'd0,      2'd0, 17'd2053},
      '{3'd0, 18'd1023, 3'd0, 1'b0, 17'd0,    17'd0,      2'd0, 17'd3071},
      '{3'd0, 18'd1024, 3'd1, 1'b0, 17'd0,    17'd0,      2'd2, 17'd0},
      '{3'd1, 18'd511,  3'd5, 1'b0, 17'd0,    17'd0,      2'd0, 17'd5631},
      '{3'd1, 18'd512,  3'd0, 1'b0, 17'd0,    17'd0,      2'd2, 17'd0},
      '{3'd2, 18'd10,   3'd7, 1'b0, 17'd0,    17'd0,      2'd0, 17'd130570},
      '{3'd2, 18'd600,  3'd2, 1'b0, 17'd0,    17'd0,      2'd2, 17'd0},
      '{3'd3, 18'd0,    3'd1, 1'b0, 17'd0,    17'd0,      2'd1, 17'd0},
      '{3'd4, 18'd2000, 3'd0, 1'b0, 17'd0,    17'd0,      2'd1, 17'd0},
      '{3'd7, 18'd0,    3'd6, 1'b1, 17'd0,    17'd131071, 2'd1, 17'd0},
      '{3'd0, 18'd2,    3'd0, 1'b1, 17'd2050, 17'd2060,   2'd3, 17'd0},
      '{3'd0, 18'd12,   3'd0, 1'b1, 17'd2050, 17'd2060,   2'd3, 17'd0},
      '{3'd0, 18'd13,   3'd0, 1'b1, 17'd2050, 17'd2060,   2'd0, 17'd2061},
      '{3'd0, 18'd1,    3'd0, 1'b1, 17'd2050, 17'd2060,   2'd0, 17'd2049},
      '{3'd0, 18'd1024, 3'd0, 1'b1, 17'd3000, 17'd3100,   2'd2, 17'd0},
      '{3'd1, 18'd3,    3'd4, 1'b1, 17'd5123, 17'd5123,   2'd3, 17'd0},
      '{3'd0, 18'd2,    3'd0, 1'b0, 17'd2050, 17'd2060,   2'd0, 17'd2050}
   };

   task automatic check(input string req_tag, input string what,
                        input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req_tag, what, actual, expected);
      end
   endtask

   task automatic write_region(input logic [1:0] s, input logic [7:0] b,
                               input logic [7:0] l);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_base = b; cfg_len = l;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Drive at a falling edge; the registered result is sampled one falling edge later.
   task automatic access(input logic [2:0] ty, input logic [17:0] off,
                         input logic [2:0] sel, input logic lk,
                         input logic [16:0] lo, input logic [16:0] hi);
      @(negedge clk);
      req = 1'b1; req_addr = {ty, off, sel};
      lock_on = lk; lock_lo = lo; lock_hi = hi;
      @(negedge clk);
      req = 1'b0; lock_on = 1'b0;
   endtask

   initial begin
      // R9 reset state
      #2;
      check("R9", "valid in reset", int'(out_valid), 0);
      check("R9", "fault in reset", int'(out_fault), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9 unconfigured region reports out of bounds
      access(3'd0, 18'd0, 3'd0, 1'b0, '0, '0);
      check("R9", "fault before config", int'(out_fault), 2);
      check("R7", "valid after request", int'(out_valid), 1);

      // R8 request in the same cycle as a write sees old values
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_base = 8'd4; cfg_len = 8'd2;
      req = 1'b1; req_addr = {3'd0, 18'd5, 3'd0};
      @(negedge clk);
      cfg_we = 1'b0; req = 1'b0;
      check("R8", "same-cycle write not seen", int'(out_fault), 2);

      write_region(2'd1, 8'd10, 8'd1);
      write_region(2'd2, 8'd255, 8'd2);

      foreach (VECS[i]) begin
         access(VECS[i].ty, VECS[i].off, VECS[i].sel, VECS[i].lk, VECS[i].lo, VECS[i].hi);
         check("R3/R4/R5/R6 fault", $sformatf("vec %0d", i), int'(out_fault), int'(VECS[i].f));
         check("R3/R6 phys", $sformatf("vec %0d", i), int'(out_phys), int'(VECS[i].ph));
         check("R1 sel", $sformatf("vec %0d", i), int'(out_sel), int'(VECS[i].sel));
      end

      // R7 idle cycle clears outputs
      @(negedge clk);
      check("R7", "idle valid", int'(out_valid), 0);
      check("R7", "idle phys", int'(out_phys), 0);

      // R8 write to select 3 changes no region
      write_region(2'd3, 8'd0, 8'd200);
      access(3'd0, 18'd1023, 3'd0, 1'b0, '0, '0);
      check("R8", "main after sel3 write", int'(out_phys), 3071);
      access(3'd1, 18'd0, 3'd0, 1'b0, '0, '0);
      check("R8", "bufA after sel3 write", int'(out_phys), 5120);
      access(3'd2, 18'd1024, 3'd0, 1'b0, '0, '0);
      check("R8", "bufB len after sel3 write", int'(out_fault), 2);

      // R2 type 5 illegal even inside a granted offset range
      access(3'd5, 18'd0, 3'd2, 1'b0, '0, '0);
      check("R2", "type 5", int'(out_fault), 1);

      // R3 rewriting a region moves its base
      write_region(2'd0, 8'd0, 8'd1);
      access(3'd0, 18'd100, 3'd0, 1'b0, '0, '0);
      check("R3", "main rebased", int'(out_phys), 100);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule